// File: doc/BRIEF.md
# UART Transmit and Receive Buffer Pair with Receive Trigger

This block holds the two byte buffers that sit between a UART's CPU-facing registers and its serial shifters. The transmit buffer takes bytes from the CPU side and hands them to the transmit shifter. The receive buffer takes bytes from the receive shifter and hands them to the CPU. Each received byte carries a small error tag that is stored beside it. Both buffers report their fill level, empty and full. A receive-data interrupt compares the receive fill against a programmed trigger level.

A single write-only control register governs the pair. One bit enables buffered operation. With buffering enabled, each side is a sixteen-entry queue. With it disabled, each side keeps only one byte. Two bits request a one-shot flush of either side, and they act only while buffering is enabled. A two-bit code picks one of four receive trigger levels. Any change of the enable bit flushes both sides. A push into a full side is dropped and sets a sticky overrun flag. A pop from an empty side leaves the read data as it was.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, buffering is disabled and the trigger code is 00. Both levels read 0, both empty flags are 1, both full flags are 0, and the interrupt and both overrun flags are 0.
- R2: Control bit 0 = 1 enables buffering. Each side then holds up to DEPTH (16) bytes and returns them first in, first out. The level output counts the stored bytes, and full rises when the level reaches 16.
- R3: Control bit 0 = 0 disables buffering. Each side then holds at most one byte, and full rises at level 1.
- R4: A push into a full side is dropped and leaves the level unchanged. It sets that side's overrun flag, which stays set until that side is flushed by a clear or by a mode change.
- R5: A pop presents the oldest byte on the read-data output one cycle later. A pop from an empty side leaves the level, the read data and the error tag unchanged.
- R6: While buffering is enabled, control bits [7:6] pick the receive trigger: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The interrupt is high while the receive level is at or above the trigger, and it drops when a pop or a flush takes the level below it.
- R7: While buffering is disabled, the trigger code has no effect and the interrupt is high exactly when the one-byte receive holder is occupied.
- R8: With buffering enabled, a control write with bit 2 = 1 empties the transmit side and leaves the receive side unchanged. A transmit push in the same cycle is discarded. With buffering disabled, the bit is ignored.
- R9: With buffering enabled, a control write with bit 1 = 1 empties the receive side, including its error tags, and leaves the transmit side unchanged. With buffering disabled, the bit is ignored.
- R10: A control write that changes bit 0 flushes both sides. A write that keeps bit 0 does not flush, and bits [5:3] have no effect.
- R11: The ERR_W-bit error tag given with each receive push is returned on the error output together with that byte's data.
- R12: A simultaneous push and pop on a side that is neither empty nor full keeps its level and preserves the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: [7:6] trigger code, [2] tx clear, [1] rx clear, [0] enable |
| tx_push | input | 1 | Write one byte into the transmit side |
| tx_wdata | input | DATA_W | Transmit push data |
| tx_pop | input | 1 | Take one byte from the transmit side |
| tx_rdata | output | DATA_W | Last byte popped from the transmit side |
| rx_push | input | 1 | Write one byte into the receive side |
| rx_wdata | input | DATA_W | Receive push data |
| rx_werr | input | ERR_W | Error tag stored with the pushed byte |
| rx_pop | input | 1 | Take one byte from the receive side |
| rx_rdata | output | DATA_W | Last byte popped from the receive side |
| rx_rerr | output | ERR_W | Error tag of the last popped byte |
| tx_level | output | $clog2(DEPTH)+1 | Transmit fill level |
| rx_level | output | $clog2(DEPTH)+1 | Receive fill level |
| tx_empty | output | 1 | Transmit side empty |
| tx_full | output | 1 | Transmit side full |
| rx_empty | output | 1 | Receive side empty |
| rx_full | output | 1 | Receive side full |
| rx_irq | output | 1 | Receive-data interrupt |
| tx_ovr | output | 1 | Sticky transmit overrun |
| rx_ovr | output | 1 | Sticky receive overrun |

## Verification
The checker follows the enable bit and the trigger code from the control writes it observes. Its properties therefore assume that the control register changes only through ctl_we, and that DEPTH is a power of two no smaller than 16. The drop, pop-from-empty and push-with-pop properties also assume that no control write lands in the same cycle, since a write may flush. The bench drives every input 5 ns after a rising edge and holds it for exactly one cycle. It never writes the control register while it is testing a push or pop corner, except in the one test that deliberately makes a clear collide with a push.

// File: rtl/uart_fifo_pair.sv
`timescale 1ns/1ps
module uart_fifo_pair #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ERR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_we,
  input  logic [7:0]                ctl_wdata,
  input  logic                      tx_push,
  input  logic [DATA_W-1:0]         tx_wdata,
  input  logic                      tx_pop,
  output logic [DATA_W-1:0]         tx_rdata,
  input  logic                      rx_push,
  input  logic [DATA_W-1:0]         rx_wdata,
  input  logic [ERR_W-1:0]          rx_werr,
  input  logic                      rx_pop,
  output logic [DATA_W-1:0]         rx_rdata,
  output logic [ERR_W-1:0]          rx_rerr,
  output logic [$clog2(DEPTH):0]    tx_level,
  output logic [$clog2(DEPTH):0]    rx_level,
  output logic                      tx_empty,
  output logic                      tx_full,
  output logic                      rx_empty,
  output logic                      rx_full,
  output logic                      rx_irq,
  output logic                      tx_ovr,
  output logic                      rx_ovr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int RW = ERR_W + DATA_W;

  logic       en;
  logic [1:0] trig;
  logic       unused_rsvd;
  assign unused_rsvd = ^ctl_wdata[5:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      trig <= 2'b00;
    end else if (ctl_we) begin
      en   <= ctl_wdata[0];
      trig <= ctl_wdata[7:6];
    end
  end

  logic mode_flip, tx_clr, rx_clr;
  assign mode_flip = ctl_we && (ctl_wdata[0] != en);
  assign tx_clr    = mode_flip || (ctl_we && en && ctl_wdata[2]);
  assign rx_clr    = mode_flip || (ctl_we && en && ctl_wdata[1]);

  logic [CW-1:0] cap;
  assign cap = en ? CW'(DEPTH) : CW'(1);

  assign tx_empty = (tx_level == '0);
  assign tx_full  = (tx_level == cap);
  assign rx_empty = (rx_level == '0);
  assign rx_full  = (rx_level == cap);

  logic tx_do_push, tx_do_pop, rx_do_push, rx_do_pop;
  assign tx_do_push = tx_push && !tx_full  && !tx_clr;
  assign tx_do_pop  = tx_pop  && !tx_empty && !tx_clr;
  assign rx_do_push = rx_push && !rx_full  && !rx_clr;
  assign rx_do_pop  = rx_pop  && !rx_empty && !rx_clr;

  // transmit side
  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [AW-1:0]     tx_wp, tx_rp;

  always_ff @(posedge clk)
    if (tx_do_push) tx_mem[tx_wp] <= tx_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp    <= '0;
      tx_rp    <= '0;
      tx_level <= '0;
      tx_ovr   <= 1'b0;
      tx_rdata <= '0;
    end else if (tx_clr) begin
      tx_wp    <= '0;
      tx_rp    <= '0;
      tx_level <= '0;
      tx_ovr   <= 1'b0;
    end else begin
      if (tx_do_push) tx_wp <= tx_wp + 1'b1;
      if (tx_do_pop) begin
        tx_rdata <= tx_mem[tx_rp];
        tx_rp    <= tx_rp + 1'b1;
      end
      tx_level <= tx_level + CW'(tx_do_push) - CW'(tx_do_pop);
      if (tx_push && tx_full) tx_ovr <= 1'b1;
    end
  end

  // receive side, error tag stored beside each byte
  logic [RW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;

  always_ff @(posedge clk)
    if (rx_do_push) rx_mem[rx_wp] <= {rx_werr, rx_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp    <= '0;
      rx_rp    <= '0;
      rx_level <= '0;
      rx_ovr   <= 1'b0;
      rx_rdata <= '0;
      rx_rerr  <= '0;
    end else if (rx_clr) begin
      rx_wp    <= '0;
      rx_rp    <= '0;
      rx_level <= '0;
      rx_ovr   <= 1'b0;
    end else begin
      if (rx_do_push) rx_wp <= rx_wp + 1'b1;
      if (rx_do_pop) begin
        {rx_rerr, rx_rdata} <= rx_mem[rx_rp];
        rx_rp <= rx_rp + 1'b1;
      end
      rx_level <= rx_level + CW'(rx_do_push) - CW'(rx_do_pop);
      if (rx_push && rx_full) rx_ovr <= 1'b1;
    end
  end

  logic [CW-1:0] trig_lvl;
  always_comb begin
    unique case (trig)
      2'b00:   trig_lvl = CW'(1);
      2'b01:   trig_lvl = CW'(4);
      2'b10:   trig_lvl = CW'(8);
      default: trig_lvl = CW'(14);
    endcase
  end

  assign rx_irq = en ? (rx_level >= trig_lvl) : !rx_empty;
endmodule

// File: rtl/uart_fifo_pair_chk.sv
`timescale 1ns/1ps
module uart_fifo_pair_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctl_we,
  input logic [1:0]             ctl_trig,
  input logic                   ctl_clr_tx,
  input logic                   ctl_clr_rx,
  input logic                   ctl_en,
  input logic                   tx_push,
  input logic                   tx_pop,
  input logic                   rx_push,
  input logic                   rx_pop,
  input logic [$clog2(DEPTH):0] tx_level,
  input logic [$clog2(DEPTH):0] rx_level,
  input logic                   tx_full,
  input logic                   tx_empty,
  input logic                   rx_empty,
  input logic                   rx_irq,
  input logic                   rx_ovr
);
  logic       en_m;
  logic [1:0] trig_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_m   <= 1'b0;
      trig_m <= 2'b00;
    end else if (ctl_we) begin
      en_m   <= ctl_en;
      trig_m <= ctl_trig;
    end
  end

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= DEPTH) && (rx_level <= DEPTH)); // R2
  AST_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_m |-> (tx_level <= 1) && (rx_level <= 1)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_push && !tx_pop && !ctl_we |=> tx_level == $past(tx_level)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr && !ctl_we |=> rx_ovr); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && rx_pop && !rx_push && !ctl_we |=> rx_empty); // R5
  AST_TRIG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    en_m && trig_m == 2'b11 && rx_level < 14 |-> !rx_irq); // R6
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_m && rx_empty |-> !rx_irq); // R7
  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && en_m && ctl_en && ctl_clr_tx |=> tx_empty); // R8
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && en_m && ctl_en && ctl_clr_rx |=> rx_empty); // R9
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && (ctl_en != en_m) |=> tx_empty && rx_empty); // R10
  AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    en_m && rx_push && rx_pop && !rx_empty && rx_level < DEPTH && !ctl_we
      |=> rx_level == $past(rx_level)); // R12
endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_trig   (ctl_wdata[7:6]),
  .ctl_clr_tx (ctl_wdata[2]),
  .ctl_clr_rx (ctl_wdata[1]),
  .ctl_en     (ctl_wdata[0]),
  .tx_push    (tx_push),
  .tx_pop     (tx_pop),
  .rx_push    (rx_push),
  .rx_pop     (rx_pop),
  .tx_level   (tx_level),
  .rx_level   (rx_level),
  .tx_full    (tx_full),
  .tx_empty   (tx_empty),
  .rx_empty   (rx_empty),
  .rx_irq     (rx_irq),
  .rx_ovr     (rx_ovr)
);

// File: tb/tb_uart_fifo_pair.sv
`timescale 1ns/1ps
module tb_uart_fifo_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic [2:0] rx_werr = '0;
  logic [7:0] tx_rdata, rx_rdata;
  logic [2:0] rx_rerr;
  logic [4:0] tx_level, rx_level;
  logic       tx_empty, tx_full, rx_empty, rx_full, rx_irq, tx_ovr, rx_ovr;

  int n_chk = 0;
  int n_bad = 0;

  uart_fifo_pair dut (.*);

  always #10 clk = ~clk;

  // {op[1:0], err[2:0], data[7:0], exp_level[4:0], exp_data[7:0], exp_err[2:0]}
  // op: 0 control write, 1 receive push, 2 receive pop
  localparam logic [28:0] VEC [10] = '{
    {2'd0, 3'd0, 8'h01, 5'd0, 8'h00, 3'd0},
    {2'd1, 3'd0, 8'hA1, 5'd1, 8'h00, 3'd0},
    {2'd1, 3'd5, 8'hB2, 5'd2, 8'h00, 3'd0},
    {2'd1, 3'd0, 8'hC3, 5'd3, 8'h00, 3'd0},
    {2'd2, 3'd0, 8'h00, 5'd2, 8'hA1, 3'd0},
    {2'd2, 3'd0, 8'h00, 5'd1, 8'hB2, 3'd5},
    {2'd1, 3'd2, 8'hD4, 5'd2, 8'h00, 3'd0},
    {2'd2, 3'd0, 8'h00, 5'd1, 8'hC3, 3'd0},
    {2'd2, 3'd0, 8'h00, 5'd0, 8'hD4, 3'd2},
    {2'd2, 3'd0, 8'h00, 5'd0, 8'hD4, 3'd2}
  };

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] w);
    ctl_we = 1'b1; ctl_wdata = w; tick(); ctl_we = 1'b0;
  endtask

  task automatic rxpush(input logic [7:0] d, input logic [2:0] e);
    rx_push = 1'b1; rx_wdata = d; rx_werr = e; tick(); rx_push = 1'b0;
  endtask

  task automatic rxpop();
    rx_pop = 1'b1; tick(); rx_pop = 1'b0;
  endtask

  task automatic txpush(input logic [7:0] d);
    tx_push = 1'b1; tx_wdata = d; tick(); tx_push = 1'b0;
  endtask

  task automatic txpop();
    tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask

  function automatic int lvl_of(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 empties", {tx_empty, rx_empty}, 3);
    check("R1 fulls", {tx_full, rx_full}, 0);
    check("R1 irq", rx_irq, 0);
    check("R1 overruns", {tx_ovr, rx_ovr}, 0);

    // R2/R11/R5 vector walk
    for (int i = 0; i < 10; i++) begin
      logic [28:0] v;
      v = VEC[i];
      case (v[28:27])
        2'd0: ctl(v[23:16]);
        2'd1: rxpush(v[23:16], v[26:24]);
        default: rxpop();
      endcase
      check($sformatf("R2 vector %0d level", i), rx_level, v[15:11]);
      if (v[28:27] == 2'd2) begin
        check($sformatf("%s vector %0d data", (i == 9) ? "R5" : "R11", i), rx_rdata, v[10:3]);
        check($sformatf("%s vector %0d err", (i == 9) ? "R5" : "R11", i), rx_rerr, v[2:0]);
      end
    end

    // R12 simultaneous push and pop
    rxpush(8'h11, 3'd0);
    rx_push = 1'b1; rx_wdata = 8'h22; rx_werr = 3'd1; rx_pop = 1'b1;
    tick();
    rx_push = 1'b0; rx_pop = 1'b0;
    check("R12 level", rx_level, 1);
    check("R12 data", rx_rdata, 8'h11);
    rxpop();
    check("R12 order", rx_rdata, 8'h22);

    // R6 trigger codes
    for (int c = 0; c < 4; c++) begin
      int lv;
      lv = lvl_of(c);
      ctl({c[1:0], 3'b000, 3'b011});
      check($sformatf("R6 code %0d cleared", c), rx_level, 0);
      for (int k = 0; k < lv - 1; k++) rxpush(8'(k), 3'd0);
      check($sformatf("R6 code %0d below", c), rx_irq, 0);
      rxpush(8'hEE, 3'd0);
      check($sformatf("R6 code %0d at level", c), rx_irq, 1);
      rxpop();
      check($sformatf("R6 code %0d after pop", c), rx_irq, 0);
    end

    // R9 receive clear leaves transmit side
    ctl(8'h07);
    txpush(8'h55);
    rxpush(8'h66, 3'd7);
    rxpush(8'h67, 3'd7);
    ctl(8'h03);
    check("R9 rx flushed", rx_level, 0);
    check("R9 tx kept", tx_level, 1);
    rxpush(8'h68, 3'd0);
    rxpop();
    check("R9 err flushed", rx_rerr, 0);
    check("R9 data", rx_rdata, 8'h68);

    // R8 transmit clear leaves receive side
    rxpush(8'h69, 3'd0);
    ctl(8'h05);
    check("R8 tx flushed", tx_level, 0);
    check("R8 rx kept", rx_level, 1);
    ctl_we = 1'b1; ctl_wdata = 8'h05; tx_push = 1'b1; tx_wdata = 8'h77;
    tick();
    ctl_we = 1'b0; tx_push = 1'b0;
    check("R8 push with clear", tx_level, 0);

    // R10 reserved bits and unchanged enable do not flush
    ctl(8'h39);
    check("R10 no flush", rx_level, 1);
    check("R10 irq trig 1", rx_irq, 1);
    rxpop();

    // R2/R4 fill transmit side
    for (int k = 0; k < 16; k++) txpush(8'(8'h80 + k));
    check("R2 tx full", tx_full, 1);
    check("R2 tx level", tx_level, 16);
    txpush(8'hFF);
    check("R4 drop level", tx_level, 16);
    check("R4 tx overrun", tx_ovr, 1);
    for (int k = 0; k < 16; k++) begin
      txpop();
      check($sformatf("R2 tx order %0d", k), tx_rdata, 8'h80 + k);
    end
    check("R2 tx empty", tx_empty, 1);
    check("R4 overrun sticky", tx_ovr, 1);
    txpop();
    check("R5 tx empty pop", tx_rdata, 8'h8F);
    ctl(8'h05);
    check("R4 overrun cleared", tx_ovr, 0);

    // R3/R7 disabled mode
    rxpush(8'h01, 3'd0);
    ctl(8'hC0);
    check("R10 disable flush", rx_level, 0);
    check("R7 idle irq", rx_irq, 0);
    rxpush(8'h31, 3'd0);
    check("R7 irq one byte", rx_irq, 1);
    check("R3 rx full", rx_full, 1);
    rxpush(8'h32, 3'd0);
    check("R3 rx capacity", rx_level, 1);
    check("R4 rx overrun", rx_ovr, 1);
    ctl(8'hC2);
    check("R9 clear ignored when disabled", rx_level, 1);
    txpush(8'h41);
    check("R3 tx full", tx_full, 1);
    ctl(8'hC4);
    check("R8 clear ignored when disabled", tx_level, 1);
    rxpop();
    check("R3 rx data", rx_rdata, 8'h31);
    rxpush(8'h33, 3'd0);

    // R10 enable flushes both
    ctl(8'h01);
    check("R10 enable tx flush", tx_level, 0);
    check("R10 enable rx flush", rx_level, 0);
    check("R10 overrun cleared", rx_ovr, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule